// File: doc/BRIEF.md
# Dual-Clock Two-Port RAM with Per-Port Width Select

This block is a simple two-port memory of 4608 bits with one write port and one read port. Each port runs on its own rising-edge clock, and the two clocks may be unrelated. Each port picks its own organisation at run time through a 2-bit width code: 512 words of 9 bits or 256 words of 18 bits. Both views share one storage array, so data written through one width can be read back through the other.

Storage is split into two 9-bit banks. An 18-bit word at address A is made of 9-bit word 2A in its low half and 9-bit word 2A+1 in its high half. The read path can either present data right after the read-clock edge that samples the address (flow-through) or one read-clock cycle later (registered), chosen by a runtime input. An active-low reset empties the read path and blocks both ports while it is low, but the stored contents are kept. The enable polarity of each port is set by a parameter.

Top module: `dual_clock_ratio_ram`

## Requirements
- R1: With width code 2'b10 (256×18) on a port, the port moves a full 18-bit word per access, and the address MSB (bit 8) is ignored, so addresses A and A+256 reach the same word.
- R2: With width code 2'b01 (512×9) on a port, only write data bits [8:0] are stored, and after a read the read data bits [17:9] are zero.
- R3: The two widths share storage: 18-bit word A holds 9-bit word 2A in bits [8:0] and 9-bit word 2A+1 in bits [17:9].
- R4: With pipe_sel low, read data for an address sampled at a read-clock rising edge is on rd_data right after that edge.
- R5: With pipe_sel high, read data appears one read-clock cycle later than with pipe_sel low, so back-to-back reads come out in order one cycle apart.
- R6: A read-clock edge with the read enable inactive leaves rd_data unchanged.
- R7: Write and read enables are active low with the default parameters; with WR_EN_HIGH and RD_EN_HIGH set to 1 they are active high and the block behaves the same otherwise.
- R8: While rst_n is low (sampled at the clock edge of each port), rd_data becomes zero, writes are blocked, and after release rd_data stays zero until the next enabled read.
- R9: Reset does not change stored memory contents.
- R10: A write with a reserved width code (2'b00 or 2'b11) stores nothing.
- R11: A read with a reserved width code leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, sampled on each port clock |
| wr_clk | input | 1 | Write clock, rising edge |
| wr_en | input | 1 | Write enable, polarity set by WR_EN_HIGH |
| wr_mode | input | 2 | Write width code: 01 = 512×9, 10 = 256×18, others reserved |
| wr_addr | input | 9 | Write address |
| wr_data | input | 18 | Write data |
| rd_clk | input | 1 | Read clock, rising edge |
| rd_en | input | 1 | Read enable, polarity set by RD_EN_HIGH |
| rd_mode | input | 2 | Read width code: 01 = 512×9, 10 = 256×18, others reserved |
| rd_addr | input | 9 | Read address |
| pipe_sel | input | 1 | 0 = flow-through read, 1 = one extra read-clock cycle |
| rd_data | output | 18 | Read data |

## Verification
The hardest case to reach from the ports is telling the registered read apart from the flow-through one, because a single isolated read shows the same final value in both modes. The stimulus therefore issues reads back to back with differing addresses, so a wrong latency puts the neighbouring word on rd_data in the checked cycle. Mixed-width mapping is driven by writing through one width and reading through the other, and the reset case writes during reset and then reads that address to show both that the write was blocked and that earlier contents survived. A second copy of the block with active-high enables runs on inverted enables and must match the first on every check.

// File: rtl/drr_pkg.sv
package drr_pkg;

  typedef enum logic [1:0] {
    MODE_RSV_LO = 2'b00,
    MODE_NARROW = 2'b01,
    MODE_WIDE   = 2'b10,
    MODE_RSV_HI = 2'b11
  } port_mode_e;

  // A port is live only for the two defined width codes.
  function automatic logic mode_ok(input logic [1:0] code);
    return (code == MODE_NARROW) || (code == MODE_WIDE);
  endfunction

endpackage

// File: rtl/drr_bank.sv
module drr_bank #(
  parameter int DATA_W = 9,
  parameter int IDX_W  = 8
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wd,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              re,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rq
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[wr_idx] <= wd;
  end

  // Output register with synchronous reset, the form block RAM offers.
  always_ff @(posedge rd_clk) begin
    if (rd_rst)  rq <= '0;
    else if (re) rq <= mem[rd_idx];
  end

endmodule

// File: rtl/drr_wr_port.sv
module drr_wr_port
  import drr_pkg::*;
#(
  parameter int NARROW_W = 9,
  parameter int ADDR_W   = 9,
  parameter bit EN_HIGH  = 1'b0,
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int IDX_W   = ADDR_W - 1
) (
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_mode,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WIDE_W-1:0]      wr_data,
  output logic [1:0]             bank_we,
  output logic [IDX_W-1:0]       bank_idx,
  output logic [1:0][NARROW_W-1:0] bank_wd
);

  logic act;
  assign act = (wr_en == EN_HIGH) && rst_n;

  always_comb begin
    bank_we    = '0;
    bank_idx   = wr_addr[IDX_W-1:0];
    bank_wd[0] = wr_data[NARROW_W-1:0];
    bank_wd[1] = wr_data[WIDE_W-1:NARROW_W];
    unique case (port_mode_e'(wr_mode))
      MODE_WIDE: begin
        // Top address bit plays no part in the 18-bit view.
        bank_we = {2{act}};
      end
      MODE_NARROW: begin
        bank_idx     = wr_addr[ADDR_W-1:1];
        bank_wd[1]   = wr_data[NARROW_W-1:0];
        bank_we[0]   = act && !wr_addr[0];
        bank_we[1]   = act &&  wr_addr[0];
      end
      default: bank_we = '0;
    endcase
  end

endmodule

// File: rtl/drr_rd_port.sv
module drr_rd_port
  import drr_pkg::*;
#(
  parameter int NARROW_W = 9,
  parameter int ADDR_W   = 9,
  parameter bit EN_HIGH  = 1'b0,
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int IDX_W   = ADDR_W - 1
) (
  input  logic                     rd_clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [1:0]               rd_mode,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     pipe_sel,
  input  logic [1:0][NARROW_W-1:0] bank_q,
  output logic [1:0]               bank_re,
  output logic [IDX_W-1:0]         bank_idx,
  output logic [WIDE_W-1:0]        rd_data
);

  logic              act;
  logic              wide;
  logic              sel_q;
  logic              narrow_q;
  logic [WIDE_W-1:0] flow_word;
  logic [WIDE_W-1:0] pipe_q;

  assign act      = (rd_en == EN_HIGH) && rst_n && mode_ok(rd_mode);
  assign wide     = (rd_mode == MODE_WIDE);
  assign bank_re  = {2{act}};
  assign bank_idx = wide ? rd_addr[IDX_W-1:0] : rd_addr[ADDR_W-1:1];

  // Lane select and width travel alongside the bank output register.
  always_ff @(posedge rd_clk) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      narrow_q <= 1'b0;
    end else if (act) begin
      sel_q    <= rd_addr[0];
      narrow_q <= !wide;
    end
  end

  always_comb begin
    if (narrow_q) flow_word = {{NARROW_W{1'b0}}, (sel_q ? bank_q[1] : bank_q[0])};
    else          flow_word = {bank_q[1], bank_q[0]};
  end

  always_ff @(posedge rd_clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= flow_word;
  end

  assign rd_data = pipe_sel ? pipe_q : flow_word;

endmodule

// File: rtl/dual_clock_ratio_ram.sv
module dual_clock_ratio_ram
  import drr_pkg::*;
#(
  parameter int NARROW_W   = 9,
  parameter int ADDR_W     = 9,
  parameter bit WR_EN_HIGH = 1'b0,
  parameter bit RD_EN_HIGH = 1'b0,
  localparam int WIDE_W    = 2 * NARROW_W,
  localparam int IDX_W     = ADDR_W - 1
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDE_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [1:0]        rd_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              pipe_sel,
  output logic [WIDE_W-1:0] rd_data
);

  localparam int BANKS = 2;

  logic [BANKS-1:0]               bank_we;
  logic [BANKS-1:0]               bank_re;
  logic [IDX_W-1:0]               wr_idx;
  logic [IDX_W-1:0]               rd_idx;
  logic [BANKS-1:0][NARROW_W-1:0] bank_wd;
  logic [BANKS-1:0][NARROW_W-1:0] bank_q;
  logic                           rd_rst;

  assign rd_rst = ~rst_n;

  drr_wr_port #(
    .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .EN_HIGH(WR_EN_HIGH)
  ) u_wr_port (
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_mode (wr_mode),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .bank_we (bank_we),
    .bank_idx(wr_idx),
    .bank_wd (bank_wd)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    drr_bank #(.DATA_W(NARROW_W), .IDX_W(IDX_W)) u_bank (
      .wr_clk(wr_clk),
      .we    (bank_we[g]),
      .wr_idx(wr_idx),
      .wd    (bank_wd[g]),
      .rd_clk(rd_clk),
      .rd_rst(rd_rst),
      .re    (bank_re[g]),
      .rd_idx(rd_idx),
      .rq    (bank_q[g])
    );
  end

  drr_rd_port #(
    .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .EN_HIGH(RD_EN_HIGH)
  ) u_rd_port (
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_mode (rd_mode),
    .rd_addr (rd_addr),
    .pipe_sel(pipe_sel),
    .bank_q  (bank_q),
    .bank_re (bank_re),
    .bank_idx(rd_idx),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/drr_checker.sv
module drr_checker #(
  parameter int NARROW_W   = 9,
  parameter bit RD_EN_HIGH = 1'b0,
  localparam int WIDE_W    = 2 * NARROW_W
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic [1:0]        wr_mode,
  input logic              rd_en,
  input logic [1:0]        rd_mode,
  input logic              pipe_sel,
  input logic [WIDE_W-1:0] rd_data,
  input logic [1:0]        bank_we
);

  logic rd_on;
  logic rd_code_ok;
  logic wr_code_ok;
  assign rd_on      = (rd_en == RD_EN_HIGH);
  assign rd_code_ok = (rd_mode == 2'b01) || (rd_mode == 2'b10);
  assign wr_code_ok = (wr_mode == 2'b01) || (wr_mode == 2'b10);

  p_reset_zero_r8: assert property (@(posedge rd_clk)
    !rst_n |=> (rd_data == '0));

  p_reset_no_write_r8: assert property (@(posedge wr_clk)
    !rst_n |-> (bank_we == 2'b00));

  p_rsv_no_write_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_code_ok |-> (bank_we == 2'b00));

  p_narrow_upper_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_on && rd_mode == 2'b01) |=> (pipe_sel || rd_data[WIDE_W-1:NARROW_W] == '0));

  p_idle_hold_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_on && !pipe_sel) |=> (pipe_sel || $stable(rd_data)));

  p_rsv_hold_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_on && !rd_code_ok && !pipe_sel) |=> (pipe_sel || $stable(rd_data)));

endmodule

bind dual_clock_ratio_ram drr_checker #(
  .NARROW_W(NARROW_W), .RD_EN_HIGH(RD_EN_HIGH)
) u_drr_checker (
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .rst_n   (rst_n),
  .wr_mode (wr_mode),
  .rd_en   (rd_en),
  .rd_mode (rd_mode),
  .pipe_sel(pipe_sel),
  .rd_data (rd_data),
  .bank_we (bank_we)
);

// File: tb/test_dual_clock_ratio_ram.sv
`timescale 1ns/1ps
module test_dual_clock_ratio_ram;

  localparam logic [1:0] M_N   = 2'b01;
  localparam logic [1:0] M_W   = 2'b10;
  localparam logic [1:0] M_R0  = 2'b00;
  localparam logic [1:0] M_R3  = 2'b11;

  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        rst_n  = 1'b0;
  logic        wr_act = 1'b0;
  logic [1:0]  wr_mode = M_W;
  logic [8:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        rd_act = 1'b0;
  logic [1:0]  rd_mode = M_W;
  logic [8:0]  rd_addr = '0;
  logic        pipe_sel = 1'b0;
  logic [17:0] rd_data_lo;
  logic [17:0] rd_data_hi;

  int total = 0;
  int bad   = 0;
  int rd_cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [17:0] val;
    int          when;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz
  always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

  always @(posedge rd_clk) rd_cyc++;

  dual_clock_ratio_ram i_dual_clock_ratio_ram (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(~wr_act), .wr_mode(wr_mode),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_clk(rd_clk), .rd_en(~rd_act),
    .rd_mode(rd_mode), .rd_addr(rd_addr), .pipe_sel(pipe_sel), .rd_data(rd_data_lo)
  );

  // R7: same stimulus, active-high enables.
  dual_clock_ratio_ram #(.WR_EN_HIGH(1'b1), .RD_EN_HIGH(1'b1)) i_dual_clock_ratio_ram_hi (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_act), .wr_mode(wr_mode),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_clk(rd_clk), .rd_en(rd_act),
    .rd_mode(rd_mode), .rd_addr(rd_addr), .pipe_sel(pipe_sel), .rd_data(rd_data_hi)
  );

  task automatic check(input logic [17:0] got, input logic [17:0] want, input string tag);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic check_both(input logic [17:0] want, input string tag);
    check(rd_data_lo, want, tag);
    check(rd_data_hi, want, {tag, " R7 active-high copy"});
  endtask

  task automatic wr(input logic [1:0] m, input logic [8:0] a, input logic [17:0] d);
    @(negedge wr_clk);
    wr_mode = m; wr_addr = a; wr_data = d; wr_act = 1'b1;
    @(negedge wr_clk);
    wr_act = 1'b0;
  endtask

  // Driver: issue one read and push the value expected on the port.
  task automatic rd_issue(input logic [1:0] m, input logic [8:0] a,
                          input logic [17:0] want, input string tag);
    exp_t e;
    @(negedge rd_clk);
    rd_mode = m; rd_addr = a; rd_act = 1'b1;
    e.val = want; e.when = rd_cyc + 1 + (pipe_sel ? 1 : 0); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd_stop();
    @(negedge rd_clk);
    rd_act = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge rd_clk);
    repeat (2) @(negedge rd_clk);
  endtask

  // Monitor: compare in the read cycle each expected item is due.
  initial begin
    forever begin
      @(negedge rd_clk);
      #1;
      while (exp_q.size() > 0 && exp_q[0].when <= rd_cyc) begin
        check_both(exp_q[0].val, exp_q[0].tag);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #500us;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam logic [17:0] W3  = 18'h2A5C3;
  localparam logic [17:0] W4  = 18'h1B0F7;
  localparam logic [17:0] N9  = 18'h3FF55;
  localparam logic [17:0] N8  = 18'h000AA;

  initial begin
    logic [17:0] held;
    logic [17:0] w4_new;
    w4_new = {N9[8:0], N8[8:0]};

    // R8: output zero under reset
    repeat (6) @(negedge rd_clk);
    check_both(18'h0, "R8 reset output");
    @(negedge rd_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge rd_clk);

    // R1, R4: wide writes, MSB of address ignored
    wr(M_W, 9'h003, W3);
    wr(M_W, 9'h104, W4);
    rd_issue(M_W, 9'h003, W3, "R1 R4 wide read a3");
    rd_issue(M_W, 9'h004, W4, "R1 R4 wide read a4 (written at 0x104)");
    rd_issue(M_W, 9'h103, W3, "R1 wide read 0x103 aliases a3");
    rd_stop(); drain();

    // R3, R2: narrow reads of a wide word
    rd_issue(M_N, 9'h006, {9'h0, W3[8:0]},  "R3 R2 narrow 6 = low half of wide 3");
    rd_issue(M_N, 9'h007, {9'h0, W3[17:9]}, "R3 R2 narrow 7 = high half of wide 3");
    rd_stop(); drain();

    // R2, R3: narrow writes, upper data ignored, read as wide
    wr(M_N, 9'h009, N9);
    wr(M_N, 9'h008, N8);
    rd_issue(M_W, 9'h004, w4_new, "R3 wide 4 from narrow 8 and 9");
    rd_issue(M_N, 9'h009, {9'h0, N9[8:0]}, "R2 narrow 9 upper data dropped");
    rd_stop(); drain();

    // R5: registered read, back to back
    @(negedge rd_clk); pipe_sel = 1'b1;
    rd_issue(M_W, 9'h003, W3, "R5 pipelined read a3");
    rd_issue(M_W, 9'h004, w4_new, "R5 pipelined read a4");
    rd_issue(M_N, 9'h006, {9'h0, W3[8:0]}, "R5 pipelined narrow 6");
    rd_stop(); drain();
    @(negedge rd_clk); pipe_sel = 1'b0;
    repeat (2) @(negedge rd_clk);

    // R6: disabled read holds
    rd_issue(M_W, 9'h003, W3, "R4 read before hold");
    rd_stop(); drain();
    held = rd_data_lo;
    @(negedge rd_clk); rd_addr = 9'h004; rd_mode = M_W;
    repeat (3) @(negedge rd_clk);
    check_both(held, "R6 disabled read keeps output");

    // R11: reserved read codes hold
    @(negedge rd_clk); rd_mode = M_R3; rd_addr = 9'h004; rd_act = 1'b1;
    repeat (2) @(negedge rd_clk);
    check_both(held, "R11 read code 11 keeps output");
    rd_mode = M_R0;
    repeat (2) @(negedge rd_clk);
    check_both(held, "R11 read code 00 keeps output");
    rd_act = 1'b0;

    // R10: reserved write codes store nothing
    wr(M_R0, 9'h003, 18'h00000);
    wr(M_R3, 9'h004, 18'h3FFFF);
    rd_issue(M_W, 9'h004, w4_new, "R10 code 11 write ignored");
    rd_issue(M_W, 9'h003, W3, "R10 code 00 write ignored");
    rd_stop(); drain();

    // R8, R9: reset blocks writes, clears output, keeps contents
    @(negedge wr_clk); rst_n = 1'b0;
    wr(M_W, 9'h003, 18'h11111);
    @(negedge rd_clk); rd_act = 1'b1; rd_mode = M_W; rd_addr = 9'h004;
    repeat (3) @(negedge rd_clk);
    check_both(18'h0, "R8 output zero during reset");
    rd_act = 1'b0;
    @(negedge rd_clk); rst_n = 1'b1;
    repeat (3) @(negedge rd_clk);
    check_both(18'h0, "R8 hold registers cleared after release");
    rd_issue(M_W, 9'h003, W3, "R8 R9 write during reset blocked, data kept");
    rd_issue(M_W, 9'h004, w4_new, "R9 contents kept over reset");
    rd_stop(); drain();

    finish_run();
  end

endmodule